// File: doc/BRIEF.md
# Parallel Code-Memory Programming Controller

This block is the device-side engine that lets an external programmer load a small on-chip code store one byte at a time. The programmer presents an address, a data byte and a 3-bit operation code, then pulls an active-low program strobe. A single strobe pulse starts a byte write that times itself. The strobe held low long enough with the erase code starts a whole-array erase. The read and signature codes return stored bytes or fixed identification bytes on a registered data output. Progress shows on a ready output, and by data polling on bit 7 of the data output while a write is running.

The store is a register array written through a single write port, so an FPGA tool can map it onto block RAM. Write and erase times are set in microseconds and converted to clock cycles with a cycles-per-microsecond parameter. Programming only clears bits: a byte can be given fresh contents only after an erase. Two lock bits, set by their own strobe codes, block the read-back of code bytes. An erase clears them again.

Top module: `flashprog_ctrl`

## Requirements
- R1: After reset is released the ready output stays low for 2^ADDR_W cycles while every byte is set to FFh, and then every address reads FFh.
- R2: A falling edge on prog_n while ready, with mode 3'b001, captures addr and din. Ready drops after that edge and stays low for WRITE_US*CLK_PER_US+2 cycles. When ready returns, the byte reads back its new value.
- R3: A write stores the bitwise AND of the old byte and din, so no bit ever goes from 0 to 1.
- R4: While a write is running, a read (mode 3'b010) of the address being written returns {~din[7], 7'b0}, and a read of any other address returns FFh. Once ready is high again, all bits of the byte are true.
- R5: dout shows the result for the mode and addr sampled two rising edges earlier. A mode other than read or signature gives FFh.
- R6: With mode 3'b011 the strobe must be sampled low on ERASE_US*CLK_PER_US+1 consecutive edges, counting the falling edge. The array is then swept to FFh over 2^ADDR_W cycles and both lock bits are cleared. Ready stays low from the falling edge to the end of the sweep. If the strobe rises earlier, the erase is abandoned and the contents are unchanged.
- R7: Signature reads (mode 3'b000) at addresses 30h, 31h and 32h return 1Eh, 51h, and then FFh when HV_VARIANT=1 or 05h when HV_VARIANT=0. Any other address returns FFh. Signature reads are not affected by the lock bits or by a busy controller.
- R8: A strobe with mode 3'b100 sets lock bit 1 and one with mode 3'b101 sets lock bit 2. Neither makes ready drop. While either lock bit is set, reads of code bytes return FFh.
- R9: A strobe edge that arrives while ready is low has no effect. A strobe with mode 3'b010, 3'b110 or 3'b111 has no effect and leaves ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Program strobe, active low |
| mode | input | 3 | Operation select code |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| dout | output | 8 | Registered read data |
| rdy | output | 1 | High when idle, low while busy |

## Verification
A wrong captured address or data byte shows up as a wrong polling value within two cycles of the strobe. It also shows as a wrong read-back once ready returns. A timing counter that is off by one moves the rising edge of ready by a cycle, and the bench model catches that on the very clock it happens. A lost lock or erase state shows on the next verify read as real data where FFh was expected, or the reverse.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MERGE,
    ST_WAIT,
    ST_HOLD,
    ST_SWEEP
  } fp_state_e;

  typedef enum logic [1:0] {
    RK_FIXED,
    RK_ARRAY
  } rd_kind_e;

  localparam logic [2:0] OP_SIG   = 3'b000;
  localparam logic [2:0] OP_WRITE = 3'b001;
  localparam logic [2:0] OP_READ  = 3'b010;
  localparam logic [2:0] OP_ERASE = 3'b011;
  localparam logic [2:0] OP_LOCK1 = 3'b100;
  localparam logic [2:0] OP_LOCK2 = 3'b101;

  function automatic logic [7:0] sig_byte(input logic [1:0] idx, input logic hv);
    logic [7:0] v;
    case (idx)
      2'd0:    v = 8'h1E;
      2'd1:    v = 8'h51;
      2'd2:    v = hv ? 8'hFF : 8'h05;
      default: v = 8'hFF;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fp_array.sv
module fp_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // simple dual-port store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd <= mem[ra];
  end

endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WRITE_CYC = 36000,
  parameter int ERASE_CYC = 240000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [7:0]        rd_data,
  output fp_state_e         state,
  output logic              rdy,
  output logic              idle,
  output logic              poll,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wreq,
  output logic [1:0]        lock,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [7:0]        wd,
  output logic [ADDR_W-1:0] ra
);
  localparam int MAXC  = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  fp_state_e         state_n;
  logic              prog_q;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sidx;
  logic [7:0]        wdat;

  assign fall = prog_q & ~prog_n;
  assign idle = (state == ST_IDLE);
  assign poll = (state == ST_FETCH) || (state == ST_MERGE) || (state == ST_WAIT);

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: begin
        if (fall && mode == OP_WRITE) state_n = ST_FETCH;
        else if (fall && mode == OP_ERASE) state_n = ST_HOLD;
      end
      ST_FETCH: state_n = ST_MERGE;
      ST_MERGE: state_n = ST_WAIT;
      ST_WAIT:  if (cnt == '0) state_n = ST_IDLE;
      ST_HOLD: begin
        if (prog_n) state_n = ST_IDLE;
        else if (cnt == '0) state_n = ST_SWEEP;
      end
      ST_SWEEP: if (sidx == '1) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SWEEP;
      rdy    <= 1'b0;
      prog_q <= 1'b1;
      cnt    <= '0;
      sidx   <= '0;
      waddr  <= '0;
      wreq   <= 8'hFF;
      wdat   <= 8'hFF;
      lock   <= 2'b00;
    end else begin
      state  <= state_n;
      rdy    <= (state_n == ST_IDLE);
      prog_q <= prog_n;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            case (mode)
              OP_WRITE: begin
                waddr <= addr;
                wreq  <= din;
              end
              OP_ERASE: cnt <= CNT_W'(ERASE_CYC - 1);
              OP_LOCK1: lock[0] <= 1'b1;
              OP_LOCK2: lock[1] <= 1'b1;
              default: ;
            endcase
          end
        end
        ST_MERGE: begin
          wdat <= wreq & rd_data;
          cnt  <= CNT_W'(WRITE_CYC - 1);
        end
        ST_WAIT, ST_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
        ST_SWEEP: begin
          sidx <= sidx + 1'b1;
          if (sidx == '1) lock <= 2'b00;
        end
        default: ;
      endcase
    end
  end

  assign we = ((state == ST_WAIT) && (cnt == '0)) || (state == ST_SWEEP);
  assign wa = (state == ST_SWEEP) ? sidx : waddr;
  assign wd = (state == ST_SWEEP) ? 8'hFF : wdat;
  assign ra = (state == ST_IDLE) ? addr : waddr;

  // R9: a busy controller keeps its captured write target
  assert_busy_keeps_target_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(waddr) && $stable(wreq)));

  // R3: the value to be committed never holds a bit the request cleared
  assert_clear_only_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> ((wdat & ~wreq) == 8'h00));

  // R6: a sweep is entered from the hold phase only with the strobe low
  assert_hold_low_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWEEP && $past(state) == ST_HOLD) |-> !$past(prog_n));

endmodule

// File: rtl/fp_readout.sv
module fp_readout
  import flashprog_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter bit HV_VARIANT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              idle,
  input  logic              poll,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit7,
  input  logic              lock_any,
  input  logic [7:0]        rd_data,
  output logic [7:0]        dout
);
  rd_kind_e   kind, kind_q;
  logic [7:0] val, val_q;

  always_comb begin
    kind = RK_FIXED;
    val  = 8'hFF;
    if (mode == OP_SIG) begin
      if (addr == ADDR_W'(8'h30))      val = sig_byte(2'd0, HV_VARIANT);
      else if (addr == ADDR_W'(8'h31)) val = sig_byte(2'd1, HV_VARIANT);
      else if (addr == ADDR_W'(8'h32)) val = sig_byte(2'd2, HV_VARIANT);
    end else if (mode == OP_READ) begin
      if (!idle) begin
        if (poll && addr == waddr) val = {~wbit7, 7'b0};
      end else if (!lock_any) begin
        kind = RK_ARRAY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= RK_FIXED;
      val_q  <= 8'hFF;
      dout   <= 8'hFF;
    end else begin
      kind_q <= kind;
      val_q  <= val;
      dout   <= (kind_q == RK_ARRAY) ? rd_data : val_q;
    end
  end

endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
  import flashprog_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int CLK_PER_US = 24,
  parameter int WRITE_US   = 1500,
  parameter int ERASE_US   = 10000,
  parameter bit HV_VARIANT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              rdy
);
  localparam int WRITE_CYC = WRITE_US * CLK_PER_US;
  localparam int ERASE_CYC = ERASE_US * CLK_PER_US;

  fp_state_e         state;
  logic              idle, poll, we;
  logic [ADDR_W-1:0] waddr, wa, ra;
  logic [7:0]        wreq, wd, rd_data;
  logic [1:0]        lock;

  fp_seq #(
    .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .prog_n(prog_n), .mode(mode), .addr(addr), .din(din),
    .rd_data(rd_data), .state(state), .rdy(rdy), .idle(idle), .poll(poll),
    .waddr(waddr), .wreq(wreq), .lock(lock), .we(we), .wa(wa), .wd(wd), .ra(ra)
  );

  fp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .ra(ra), .rd(rd_data)
  );

  fp_readout #(.ADDR_W(ADDR_W), .HV_VARIANT(HV_VARIANT)) u_readout (
    .clk(clk), .rst(rst), .mode(mode), .addr(addr), .idle(idle), .poll(poll),
    .waddr(waddr), .wbit7(wreq[7]), .lock_any(|lock), .rd_data(rd_data),
    .dout(dout)
  );

  // R2: ready only drops after the strobe was seen low
  assert_busy_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> !$past(prog_n));

  // R8: a locked, idle verify read yields FFh two edges later
  assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (rdy && (lock != 2'b00) && mode == OP_READ) |=> ##1 (dout == 8'hFF));

  // R7: first signature byte is fixed
  assert_sig_first_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_SIG && addr == ADDR_W'(8'h30)) |=> ##1 (dout == 8'h1E));

  // R4: data polling inverts the top bit of the byte in flight
  assert_poll_bit7_R4: assert property (@(posedge clk) disable iff (rst)
    (!rdy && poll && mode == OP_READ && addr == waddr) |=> ##1 (dout[7] == ~$past(wreq[7], 2)));

endmodule

// File: tb/sim_flashprog_ctrl.sv
module sim_flashprog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int CPU   = 2;
  localparam int WUS   = 4;
  localparam int EUS   = 5;
  localparam bit HV    = 1'b0;
  localparam int WCYC  = WUS * CPU;
  localparam int ECYC  = EUS * CPU;
  localparam int DEPTH = 1 << AW;

  localparam logic [2:0] M_SIG = 3'b000, M_WR = 3'b001, M_RD = 3'b010, M_ER = 3'b011,
                         M_L1 = 3'b100, M_L2 = 3'b101, M_NOP = 3'b110;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_n = 1'b1;
  logic [2:0]    mode = 3'b010;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashprog_ctrl #(
    .ADDR_W(AW), .CLK_PER_US(CPU), .WRITE_US(WUS), .ERASE_US(EUS), .HV_VARIANT(HV)
  ) u0 (
    .clk(clk), .rst(rst), .prog_n(prog_n), .mode(mode), .addr(addr), .din(din),
    .dout(dout), .rdy(rdy)
  );

  int    total = 0;
  int    bad = 0;
  string phase = "R1";

  // behavioural reference: 0 idle, 1 writing, 2 erase hold, 3 sweeping
  logic [7:0]    mm [DEPTH];
  int            kind = 3;
  int            left = DEPTH;
  logic [AW-1:0] m_wa = '0;
  logic [7:0]    m_wd = 8'hFF;
  bit            l1 = 0, l2 = 0, pprev = 1;
  logic [7:0]    pend = 8'hFF, exp_d = 8'hFF, r;
  bit            exp_r = 0;
  bit            started = 0;

  function automatic logic [7:0] msig(input logic [AW-1:0] a);
    if (a == 6'h30) return 8'h1E;
    if (a == 6'h31) return 8'h51;
    if (a == 6'h32) return HV ? 8'hFF : 8'h05;
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      kind = 3; left = DEPTH; l1 = 0; l2 = 0; pprev = 1;
      pend = 8'hFF; exp_d = 8'hFF; exp_r = 0;
    end else begin
      r = 8'hFF;
      if (mode == M_SIG) r = msig(addr);
      else if (mode == M_RD) begin
        if (kind == 1) r = (addr == m_wa) ? {~m_wd[7], 7'b0} : 8'hFF;
        else if (kind != 0) r = 8'hFF;
        else if (l1 || l2) r = 8'hFF;
        else r = mm[addr];
      end
      exp_d = pend;
      pend  = r;
      case (kind)
        0: if (pprev && !prog_n) begin
          if (mode == M_WR) begin kind = 1; left = WCYC + 2; m_wa = addr; m_wd = din; end
          else if (mode == M_ER) begin kind = 2; left = ECYC; end
          else if (mode == M_L1) l1 = 1;
          else if (mode == M_L2) l2 = 1;
        end
        1: begin
          left--;
          if (left == 0) begin mm[m_wa] = mm[m_wa] & m_wd; kind = 0; end
        end
        2: begin
          if (prog_n) kind = 0;
          else begin
            left--;
            if (left == 0) begin kind = 3; left = DEPTH; end
          end
        end
        default: begin
          left--;
          if (left == 0) begin
            for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
            l1 = 0; l2 = 0; kind = 0;
          end
        end
      endcase
      exp_r = (kind == 0);
      pprev = prog_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(dout === exp_d, {phase, " dout"}, dout, exp_d);
      chk(rdy === exp_r, {phase, " rdy"}, {7'b0, rdy}, {7'b0, exp_r});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d, input int hold);
    mode = m; addr = a; din = d; prog_n = 1'b0;
    tick(hold);
    prog_n = 1'b1;
  endtask

  task automatic wait_idle();
    int g = 0;
    tick(1);
    while (!(exp_r && rdy) && g < 1000) begin tick(1); g++; end
  endtask

  task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] want, input string req);
    mode = m; addr = a;
    tick(3);
    chk(dout === want, req, dout, want);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", total);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R1: busy initialising, then blank
    tick(1);
    chk(rdy === 1'b0, "R1 busy after reset", {7'b0, rdy}, 8'h00);
    wait_idle();
    rd(M_RD, 6'd0, 8'hFF, "R1");
    rd(M_RD, 6'd63, 8'hFF, "R1");

    phase = "R5";
    rd(M_NOP, 6'd0, 8'hFF, "R5");

    phase = "R2";
    strobe(M_WR, 6'd3, 8'hA5, 1);
    phase = "R4";
    rd(M_RD, 6'd3, 8'h00, "R4 polling");
    rd(M_RD, 6'd4, 8'hFF, "R4 other address");
    chk(rdy === 1'b0, "R2 busy", {7'b0, rdy}, 8'h00);
    wait_idle();
    rd(M_RD, 6'd3, 8'hA5, "R2");

    phase = "R3";
    strobe(M_WR, 6'd3, 8'h5A, 1);
    wait_idle();
    rd(M_RD, 6'd3, 8'h00, "R3");
    strobe(M_WR, 6'd7, 8'hF0, 1);
    wait_idle();
    strobe(M_WR, 6'd7, 8'h3C, 1);
    wait_idle();
    rd(M_RD, 6'd7, 8'h30, "R3");

    phase = "R9";
    strobe(M_WR, 6'd5, 8'h0F, 1);
    tick(2);
    strobe(M_WR, 6'd6, 8'h00, 1);
    wait_idle();
    rd(M_RD, 6'd6, 8'hFF, "R9 ignored strobe");
    rd(M_RD, 6'd5, 8'h0F, "R9");
    strobe(M_NOP, 6'd5, 8'h00, 1);
    tick(2);
    chk(rdy === 1'b1, "R9 unused code", {7'b0, rdy}, 8'h01);

    phase = "R7";
    rd(M_SIG, 6'h30, 8'h1E, "R7");
    rd(M_SIG, 6'h31, 8'h51, "R7");
    rd(M_SIG, 6'h32, 8'h05, "R7");
    rd(M_SIG, 6'h33, 8'hFF, "R7");

    phase = "R6";
    strobe(M_ER, 6'd0, 8'h00, 4);
    wait_idle();
    rd(M_RD, 6'd3, 8'h00, "R6 abandoned erase");

    phase = "R8";
    strobe(M_L1, 6'd0, 8'h00, 1);
    tick(1);
    chk(rdy === 1'b1, "R8 no busy", {7'b0, rdy}, 8'h01);
    rd(M_RD, 6'd5, 8'hFF, "R8 lock1");
    rd(M_SIG, 6'h31, 8'h51, "R7 while locked");

    phase = "R6";
    strobe(M_ER, 6'd0, 8'h00, 12);
    wait_idle();
    rd(M_RD, 6'd7, 8'hFF, "R6 erased");
    strobe(M_WR, 6'd3, 8'h12, 1);
    wait_idle();
    rd(M_RD, 6'd3, 8'h12, "R6 locks cleared");

    phase = "R8";
    strobe(M_L2, 6'd0, 8'h00, 1);
    rd(M_RD, 6'd3, 8'hFF, "R8 lock2");

    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule